// File: doc/BRIEF.md
# Pipelined Constant Modular Adder

This block adds a 16-bit operand to a 16-bit constant, wrapping modulo 2^16, in a four-stage pipeline that accepts one operand per cycle. The addition is cut into 4-bit slices. Each stage finishes one slice and registers its 1-bit carry, along with the finished low nibbles and the operand bits that are still waiting. The short adders keep the clock period small.

The constant is never added directly. Each slice owns a 16-entry row of 5-bit values. Entry `v` of slice `s` holds `v` plus nibble `s` of the constant, and bit 4 of the entry is that nibble's carry. A load request rewrites all the rows to install a new constant. The adder logic itself stays the same. A load is accepted only while the pipeline holds no valid data. The sweep then writes one entry index per cycle in every slice at once, and the ready flag stays low until the sweep is done.

Top module: `const_mod_adder`

## Requirements
- R1: For every accepted operand x, `out_data` equals (x + K) mod 2^16, where K is the constant installed by the most recent completed load.
- R2: An operand is accepted at a rising edge when `in_valid` is 1 and no load is requested or running. Its result appears with `out_valid` = 1 exactly 4 clock edges later. Back-to-back operands give one result per cycle, and each accepted operand produces exactly one result.
- R3: After reset, `out_valid` is 0, `cfg_ready` is 1 and the installed constant is 0, so results equal the operands.
- R4: `cfg_ready` is 1 only when no valid operand is inside the pipeline (output register included) and no table sweep is running.
- R5: When `cfg_load` is 1 at an edge where `cfg_ready` is 1, `cfg_key` is captured. `cfg_ready` is then 0 for exactly 16 cycles while the rows are rewritten. Every operand accepted after the sweep uses the new constant.
- R6: When `cfg_load` is 1 while `cfg_ready` is 0, the request is ignored: no sweep starts, and later results still use the old constant.
- R7: When `in_valid` is 1 during a sweep, or in the same cycle as an accepted load request, the operand is discarded and produces no result.
- R8: Carries ripple correctly across all four slices. A sum of 2^16 or more wraps, and its carry out of bit 15 is dropped. For example, x = (~K + 1) mod 2^16 gives 0, and x = ~K gives 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present |
| in_data | input | 16 | Variable operand |
| out_valid | output | 1 | Result present |
| out_data | output | 16 | Sum modulo 2^16 |
| cfg_load | input | 1 | Request to install a new constant |
| cfg_key | input | 16 | Constant to install, captured with an accepted request |
| cfg_ready | output | 1 | Pipeline empty and no sweep running; a load may be requested |

## Verification
The bench builds the block with its default parameters: a 16-bit data path and 4-bit slices. That gives four pipeline stages, 16-entry rows and a 16-cycle sweep, so every slice carry and the full four-stage ripple can be reached with a few chosen operands per constant. Several constants are installed in turn, among them all-ones, so that each row is rewritten with different contents. Operands are also driven during a sweep, together with a load request, and behind a refused request, to show that the acceptance rules hold at the ports.

// File: rtl/cma_pkg.sv
package cma_pkg;

  typedef enum logic {
    LD_IDLE  = 1'b0,
    LD_SWEEP = 1'b1
  } load_state_e;

  // number of nibble slices a data word is cut into
  function automatic int slice_count(input int data_w, input int slice_w);
    return data_w / slice_w;
  endfunction

  // number of entries in one slice row
  function automatic int row_entries(input int slice_w);
    return 1 << slice_w;
  endfunction

endpackage

// File: rtl/cma_table.sv
module cma_table #(
  parameter int DATA_W  = 16,
  parameter int SLICE_W = 4,
  localparam int NSLICE = cma_pkg::slice_count(DATA_W, SLICE_W),
  localparam int NENT   = cma_pkg::row_entries(SLICE_W),
  localparam int EW     = SLICE_W + 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                load_go,
  input  logic [DATA_W-1:0]                   load_key,
  output logic                                load_busy,
  output logic [NSLICE-1:0][NENT-1:0][EW-1:0] tbl
);
  import cma_pkg::*;

  load_state_e         state_q;
  logic [SLICE_W-1:0]  idx_q;
  logic [DATA_W-1:0]   key_q;
  logic                last_idx;

  // entry value: row index plus key nibble, bit SLICE_W is the slice carry
  function automatic logic [EW-1:0] entry_val(input logic [SLICE_W-1:0] v,
                                              input logic [SLICE_W-1:0] k);
    return {1'b0, v} + {1'b0, k};
  endfunction

  assign last_idx  = (idx_q == SLICE_W'(NENT - 1));
  assign load_busy = (state_q == LD_SWEEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      idx_q   <= '0;
      key_q   <= '0;
      for (int s = 0; s < NSLICE; s++) begin
        for (int i = 0; i < NENT; i++) begin
          tbl[s][i] <= entry_val(SLICE_W'(i), '0);
        end
      end
    end else begin
      unique case (state_q)
        LD_IDLE: begin
          if (load_go) begin
            key_q   <= load_key;
            idx_q   <= '0;
            state_q <= LD_SWEEP;
          end
        end
        LD_SWEEP: begin
          for (int s = 0; s < NSLICE; s++) begin
            tbl[s][idx_q] <= entry_val(idx_q, key_q[s*SLICE_W +: SLICE_W]);
          end
          idx_q <= idx_q + 1'b1;
          if (last_idx) begin
            state_q <= LD_IDLE;
          end
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cma_stage.sv
module cma_stage #(
  parameter int DATA_W  = 16,
  parameter int SLICE_W = 4,
  parameter int STAGE   = 0,
  localparam int NENT   = cma_pkg::row_entries(SLICE_W),
  localparam int EW     = SLICE_W + 1,
  localparam int LO     = STAGE * SLICE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_v,
  input  logic [DATA_W-1:0]         in_word,
  input  logic                      in_c,
  input  logic [NENT-1:0][EW-1:0]   row,
  output logic                      out_v,
  output logic [DATA_W-1:0]         out_word,
  output logic                      out_c
);

  logic [SLICE_W-1:0] nib;
  logic [EW-1:0]      ent;
  logic [EW-1:0]      sum;
  logic               slice_carry;
  logic [DATA_W-1:0]  next_word;

  // narrow add: looked-up entry plus the carry from the slice below
  function automatic logic [EW-1:0] slice_sum(input logic [EW-1:0] e,
                                              input logic c);
    return e + {{SLICE_W{1'b0}}, c};
  endfunction

  assign nib         = in_word[LO +: SLICE_W];
  assign ent         = row[nib];
  assign sum         = slice_sum(ent, in_c);
  assign slice_carry = sum[SLICE_W];

  always_comb begin
    next_word                 = in_word;
    next_word[LO +: SLICE_W]  = sum[SLICE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v    <= 1'b0;
      out_word <= '0;
      out_c    <= 1'b0;
    end else begin
      out_v <= in_v;
      if (in_v) begin
        out_word <= next_word;
        out_c    <= slice_carry;
      end
    end
  end

endmodule

// File: rtl/const_mod_adder.sv
module const_mod_adder #(
  parameter int DATA_W  = 16,
  parameter int SLICE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              cfg_load,
  input  logic [DATA_W-1:0] cfg_key,
  output logic              cfg_ready
);
  localparam int NSLICE = cma_pkg::slice_count(DATA_W, SLICE_W);
  localparam int NENT   = cma_pkg::row_entries(SLICE_W);
  localparam int EW     = SLICE_W + 1;
  localparam int TBL_W  = NSLICE * NENT * EW;

  logic                                vld   [NSLICE+1];
  logic [DATA_W-1:0]                   word  [NSLICE+1];
  logic                                cry   [NSLICE+1];
  logic [NSLICE-1:0][NENT-1:0][EW-1:0] tbl;
  logic [TBL_W-1:0]                    tbl_flat;
  logic                                load_busy;
  logic                                load_go;
  logic                                in_accept;
  logic                                pipe_busy;
  logic                                wrap_flag;

  // any valid operand held in a stage register
  always_comb begin
    pipe_busy = 1'b0;
    for (int i = 1; i <= NSLICE; i++) begin
      pipe_busy = pipe_busy | vld[i];
    end
  end

  assign cfg_ready = !load_busy && !pipe_busy;
  assign load_go   = cfg_load && cfg_ready;
  assign in_accept = in_valid && !load_busy && !load_go;

  assign vld[0]  = in_accept;
  assign word[0] = in_data;
  assign cry[0]  = 1'b0;

  cma_table #(
    .DATA_W  (DATA_W),
    .SLICE_W (SLICE_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_go   (load_go),
    .load_key  (cfg_key),
    .load_busy (load_busy),
    .tbl       (tbl)
  );

  for (genvar g = 0; g < NSLICE; g++) begin : g_stage
    cma_stage #(
      .DATA_W  (DATA_W),
      .SLICE_W (SLICE_W),
      .STAGE   (g)
    ) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_v     (vld[g]),
      .in_word  (word[g]),
      .in_c     (cry[g]),
      .row      (tbl[g]),
      .out_v    (vld[g+1]),
      .out_word (word[g+1]),
      .out_c    (cry[g+1])
    );
  end

  assign out_valid = vld[NSLICE];
  assign out_data  = word[NSLICE];
  // carry out of the top slice is dropped from the result
  assign wrap_flag = cry[NSLICE];
  assign tbl_flat  = tbl;

endmodule

// File: rtl/cma_checker.sv
module cma_checker #(
  parameter int DATA_W  = 16,
  parameter int SLICE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] in_data,
  input logic              in_accept,
  input logic [DATA_W-1:0] cfg_key,
  input logic              cfg_ready,
  input logic              load_go,
  input logic              load_busy,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              wrap_flag,
  input logic [cma_pkg::slice_count(DATA_W, SLICE_W) *
               cma_pkg::row_entries(SLICE_W) * (SLICE_W + 1) - 1:0] tbl_flat
);
  localparam int LAT  = cma_pkg::slice_count(DATA_W, SLICE_W);
  localparam int NENT = cma_pkg::row_entries(SLICE_W);
  localparam int CW   = $clog2(NENT + 1) + 1;

  logic [DATA_W-1:0]             key_m;
  logic [LAT-1:0]                sr_v;
  logic [LAT-1:0]                sr_w;
  logic [LAT-1:0][DATA_W-1:0]    sr_d;
  logic [DATA_W:0]               wide_sum;
  logic [CW-1:0]                 busy_cnt;

  assign wide_sum = {1'b0, in_data} + {1'b0, key_m};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_m    <= '0;
      sr_v     <= '0;
      sr_w     <= '0;
      sr_d     <= '0;
      busy_cnt <= '0;
    end else begin
      if (load_go) key_m <= cfg_key;
      for (int i = LAT - 1; i > 0; i--) begin
        sr_v[i] <= sr_v[i-1];
        sr_w[i] <= sr_w[i-1];
        sr_d[i] <= sr_d[i-1];
      end
      sr_v[0] <= in_accept;
      sr_w[0] <= wide_sum[DATA_W];
      sr_d[0] <= wide_sum[DATA_W-1:0];
      busy_cnt <= load_busy ? busy_cnt + 1'b1 : '0;
    end
  end

  // R1: sum modulo 2^DATA_W with the installed constant
  p_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data == sr_d[LAT-1]));

  // R2: each accepted operand leaves exactly LAT edges later
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == sr_v[LAT-1]));

  // R4: ready implies empty output and no sweep
  p_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |-> (!out_valid && !load_busy));

  // R5: sweep lasts one cycle per row entry
  p_sweep_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_busy) |-> (busy_cnt == CW'(NENT)));

  // R6: table contents change only during a sweep
  p_table_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_busy |=> $stable(tbl_flat));

  // R7: no operand is taken while loading
  p_no_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_busy || load_go) |-> !in_accept);

  // R8: dropped top carry matches the wide sum
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (wrap_flag == sr_w[LAT-1]));

endmodule

bind const_mod_adder cma_checker #(
  .DATA_W  (DATA_W),
  .SLICE_W (SLICE_W)
) u_cma_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_data   (in_data),
  .in_accept (in_accept),
  .cfg_key   (cfg_key),
  .cfg_ready (cfg_ready),
  .load_go   (load_go),
  .load_busy (load_busy),
  .out_valid (out_valid),
  .out_data  (out_data),
  .wrap_flag (wrap_flag),
  .tbl_flat  (tbl_flat)
);

// File: tb/const_mod_adder_tb.sv
module const_mod_adder_tb;
  localparam int LAT  = 4;
  localparam int SWEEP = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic        out_valid;
  logic [15:0] out_data;
  logic        cfg_load;
  logic [15:0] cfg_key;
  logic        cfg_ready;

  int          n_vec = 0;
  int          n_bad = 0;
  int          out_cnt = 0;
  bit          done = 1'b0;
  bit          acc_ok = 1'b1;
  logic [15:0] bench_key = 16'h0000;
  string       tag = "R1";

  logic [LAT-1:0]        mv;
  logic [LAT-1:0][15:0]  md;

  always #5 clk = ~clk;

  const_mod_adder u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .cfg_load  (cfg_load),
    .cfg_key   (cfg_key),
    .cfg_ready (cfg_ready)
  );

  // bench expectation: x + K written as x minus the negated constant
  always @(posedge clk) begin
    if (!rst_n) begin
      mv <= '0;
      md <= '0;
    end else begin
      mv <= {mv[LAT-2:0], in_valid && acc_ok};
      md <= {md[LAT-2:0], in_data - (16'h0000 - bench_key)};
    end
  end

  always @(negedge clk) begin
    if (rst_n && (mv[LAT-1] || out_valid)) begin
      n_vec++;
      if (out_valid !== mv[LAT-1]) begin
        n_bad++;
        $display("FAIL R2 out_valid act=%0b exp=%0b", out_valid, mv[LAT-1]);
      end else if (out_data !== md[LAT-1]) begin
        n_bad++;
        $display("FAIL %s out_data act=%h exp=%h", tag, out_data, md[LAT-1]);
      end
    end
    if (rst_n && out_valid) out_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] x);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state;
    tag = "R3";
    chk(cfg_ready === 1'b1, "R3 ready after reset", int'(cfg_ready), 1);
    chk(out_valid === 1'b0, "R3 no output after reset", int'(out_valid), 0);
    drive(16'h1234);
    drive(16'hFFFF);
    drive(16'h0000);
    idle(LAT + 2);
  endtask

  task automatic t_load(input logic [15:0] key);
    int n;
    while (!cfg_ready) @(negedge clk);
    cfg_load = 1'b1;
    cfg_key  = key;
    @(negedge clk);
    cfg_load  = 1'b0;
    bench_key = key;
    n = 0;
    while (!cfg_ready && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk(n == SWEEP, "R5 sweep length", n, SWEEP);
  endtask

  task automatic t_burst_busy;
    tag = "R2";
    drive(16'h0F0F);
    @(negedge clk);
    chk(cfg_ready === 1'b0, "R4 ready low with data in flight", int'(cfg_ready), 0);
    in_data = 16'hF0F0;
    drive(16'h8001);
    drive(16'h7FFE);
    idle(LAT + 1);
    chk(cfg_ready === 1'b1, "R4 ready high after drain", int'(cfg_ready), 1);
  endtask

  task automatic t_random(input int n);
    tag = "R1";
    for (int i = 0; i < n; i++) drive(16'($urandom));
    idle(LAT + 2);
  endtask

  task automatic t_carry;
    tag = "R8";
    drive(~bench_key);
    drive(16'(~bench_key + 16'h0001));
    drive(16'h0000);
    drive(16'hFFFF);
    drive(16'(16'h0010 - bench_key[3:0]));
    drive(16'(16'h1000 - bench_key[11:0]));
    idle(LAT + 2);
  endtask

  task automatic t_load_refused;
    int c0;
    tag = "R6";
    c0 = out_cnt;
    drive(16'h2222);
    @(negedge clk);
    in_data  = 16'h3333;
    cfg_load = 1'b1;
    cfg_key  = 16'hDEAD;
    @(negedge clk);
    cfg_load = 1'b0;
    in_valid = 1'b0;
    repeat (LAT + 2) @(negedge clk);
    chk(cfg_ready === 1'b1, "R6 refused load starts no sweep", int'(cfg_ready), 1);
    chk(out_cnt - c0 == 2, "R6 both operands produced", out_cnt - c0, 2);
    drive(16'h4444);
    idle(LAT + 2);
  endtask

  task automatic t_traffic_during_load(input logic [15:0] key);
    int c0;
    int n;
    tag = "R7";
    while (!cfg_ready) @(negedge clk);
    c0 = out_cnt;
    acc_ok   = 1'b0;
    cfg_load = 1'b1;
    cfg_key  = key;
    in_valid = 1'b1;
    in_data  = 16'h5A5A;
    for (int i = 0; i < SWEEP - 1; i++) begin
      @(negedge clk);
      cfg_load = 1'b0;
      in_data  = 16'(16'h0100 + i);
    end
    @(negedge clk);
    in_valid = 1'b0;
    n = 0;
    while (!cfg_ready && n < 100) begin
      n++;
      @(negedge clk);
    end
    acc_ok    = 1'b1;
    bench_key = key;
    repeat (LAT + 1) @(negedge clk);
    chk(out_cnt - c0 == 0, "R7 no result from discarded operands", out_cnt - c0, 0);
    tag = "R5";
    drive(16'h5A5A);
    drive(16'hFFFF);
    idle(LAT + 2);
  endtask

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    cfg_load = 1'b0;
    cfg_key  = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state;
    t_burst_busy;
    t_load(16'h3A5C);
    t_carry;
    t_random(40);
    t_load(16'hFFFF);
    t_carry;
    t_random(30);
    t_load_refused;
    t_traffic_during_load(16'h0001);
    t_carry;
    t_random(20);
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule